// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a 32-bit interval timer for an interrupt controller. The count advances on a fixed bus tick (a one-cycle enable pulse at 100 MHz, so one tick is 10 ns). A programmable power-of-two prescaler sits between the tick and the count. Software programs three things through single-cycle register writes: a divide configuration, an initial count and a timer entry. The entry holds the interrupt vector, a mask bit and a periodic-mode bit.

Writing the initial count loads the count and restarts timing. The count then falls by one every divisor ticks. When it expires, the block raises a one-cycle interrupt request that carries the programmed vector. In periodic mode the count reloads from the initial value at expiry. In one-shot mode it stops at zero. The expiry period is 10 ns times the initial count times the divisor.

The current count, the divide configuration and the timer entry are all visible on output ports. A register bus outside the block reads them there.

Top module: `tmr_div_timer`

## Requirements
- R1: A divide-configuration write (wr_sel_i = 0) stores only data bits 3, 1 and 0. div_cfg_o shows those bits in place, and every other bit reads 0.
- R2: The divide code is {bit3, bit1, bit0} of the configuration. The divisor is 2 to the power ((code + 1) mod 8), so code 000 divides by 2, code 100 by 32, code 110 by 128 and code 111 by 1.
- R3: Only cycles with tick_i high advance the prescaler. With tick_i low, the current count holds.
- R4: An initial-count write (wr_sel_i = 1) loads count_o with the data in the next cycle and restarts the prescaler. From then on count_o equals the initial count minus floor(ticks since load / divisor).
- R5: An initial count of zero leaves the timer stopped. count_o stays 0 and no request is raised.
- R6: In one-shot mode (entry bit 17 clear), the count stops at 0 after expiry and holds there, and exactly one request is raised.
- R7: In periodic mode (entry bit 17 set), the same edge that takes the count past 1 reloads it with the initial count, and each expiry raises one request.
- R8: An expiry drives irq_o high for one cycle in the cycle after the count reaches zero or reloads. In that cycle irq_vec_o carries entry bits 7:0.
- R9: When entry bit 16 (mask) is set, an expiry raises no request, but periodic reload still happens.
- R10: An entry write (wr_sel_i = 2) stores vector bits 7:0, mask bit 16 and periodic bit 17; all other entry bits read 0. While sw_en_i is low, the mask bit is stored as 1 whatever the data says. Reset leaves the initial count, count_o and div_cfg_o at 0 and the entry at mask only (0x00010000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bus tick enable, one pulse per 10 ns time unit |
| sw_en_i | input | 1 | Controller software-enabled; low forces the mask on entry writes |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 divide, 1 initial count, 2 timer entry, 3 none |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current count |
| div_cfg_o | output | 32 | Divide configuration readback |
| entry_o | output | 32 | Timer entry readback |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector carried with the request |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a 7-bit prescaler. Holding tick_i high every cycle puts even the divide-by-128 step within a few hundred cycles. The bench tests five divide codes at both edges of each prescaler step, covering all three configuration bits and the wrap of code 111 to divide-by-1. Small initial counts then make periodic reloads, one-shot stops and masked expiries visible in a few cycles each.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int VEC_W     = 8;
  localparam int MAX_SHIFT = 7;
  localparam int PRE_W     = $clog2((1 << MAX_SHIFT));
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_LVT  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } lvt_t;

  // scrambled code {b3,b1,b0}; shift wraps modulo 8
  function automatic logic [2:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1], cfg[0]} + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_en_i,
  input  logic       div_we_i,
  input  logic [3:0] div_wdata_i,
  input  logic       lvt_we_i,
  input  lvt_t       lvt_wdata_i,
  output logic [3:0] div_cfg_o,
  output lvt_t       lvt_o
);
  logic [3:0] div_q;
  lvt_t       lvt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      lvt_q <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
    end else begin
      if (div_we_i) div_q <= {div_wdata_i[3], 1'b0, div_wdata_i[1:0]};
      if (lvt_we_i) begin
        lvt_q      <= lvt_wdata_i;
        lvt_q.mask <= lvt_wdata_i.mask | ~sw_en_i;
      end
    end
  end

  assign div_cfg_o = div_q;
  assign lvt_o     = lvt_q;

  p_mask_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvt_we_i && !sw_en_i) |=> lvt_q.mask);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [2:0] shift_i,
  output logic       step_o
);
  localparam int FULL_W = PRE_W + 1;

  logic [PRE_W-1:0]  pre_q;
  logic [FULL_W-1:0] full;
  logic [PRE_W-1:0]  last;

  assign full   = (FULL_W'(1) << shift_i) - FULL_W'(1);
  assign last   = full[PRE_W-1:0];
  // >= tolerates a divisor shrinking mid-count
  assign step_o = run_i && tick_i && (pre_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i || !run_i) pre_q <= '0;
    else if (tick_i)            pre_q <= step_o ? '0 : pre_q + PRE_W'(1);
  end

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i && run_i) |=> (pre_q == $past(pre_q)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q, cnt_q;

  assign run_o    = (cnt_q != '0);
  assign expire_o = step_i && !load_i && (cnt_q == CNT_W'(1));
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cnt_q  <= load_val_i;
    end else if (step_i && run_o) begin
      if (cnt_q == CNT_W'(1)) cnt_q <= periodic_i ? init_q : '0;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_zero_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (cnt_q == '0));
  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && periodic_i) |=> (cnt_q == init_q));
endmodule

// File: rtl/tmr_div_timer.sv
module tmr_div_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sw_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] div_cfg_o,
  output logic [DATA_W-1:0] entry_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  sel_e       sel;
  logic       div_we, lvt_we, load;
  logic [3:0] div_cfg;
  lvt_t       lvt, lvt_wdata;
  logic       step, run, expire;
  logic       irq_q;
  logic [VEC_W-1:0] vec_q;

  assign sel    = sel_e'(wr_sel_i);
  assign div_we = wr_en_i && (sel == SEL_DIV);
  assign load   = wr_en_i && (sel == SEL_INIT);
  assign lvt_we = wr_en_i && (sel == SEL_LVT);

  assign lvt_wdata = '{periodic: wr_data_i[PER_BIT], mask: wr_data_i[MASK_BIT],
                       vec: wr_data_i[VEC_W-1:0]};

  logic unused_ok;
  assign unused_ok = ^{wr_data_i[DATA_W-1:PER_BIT+1], wr_data_i[MASK_BIT-1:VEC_W]};

  tmr_cfg_regs u_regs (
    .clk_i, .rst_ni, .sw_en_i,
    .div_we_i(div_we), .div_wdata_i(wr_data_i[3:0]),
    .lvt_we_i(lvt_we), .lvt_wdata_i(lvt_wdata),
    .div_cfg_o(div_cfg), .lvt_o(lvt)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clear_i(load), .run_i(run), .tick_i,
    .shift_i(div_shift(div_cfg)), .step_o(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(wr_data_i[CNT_W-1:0]),
    .step_i(step), .periodic_i(lvt.periodic),
    .count_o, .run_o(run), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !lvt.mask;
      if (expire) vec_q <= lvt.vec;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    div_cfg_o        = '0;
    div_cfg_o[3:0]   = div_cfg;
    entry_o          = '0;
    entry_o[VEC_W-1:0] = lvt.vec;
    entry_o[MASK_BIT]  = lvt.mask;
    entry_o[PER_BIT]   = lvt.periodic;
  end

  p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(lvt.mask));
  p_irq_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vec_o == $past(lvt.vec)));
endmodule

// File: tb/tmr_div_timer_bench.sv
`timescale 1ns/1ps
module tmr_div_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sw_en = 1'b1, we = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wd = '0;
  logic [31:0] count, div_cfg, entry;
  logic        irq;
  logic [7:0]  vec;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  tmr_div_timer u_tmr_div_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sw_en_i(sw_en),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wd),
    .count_o(count), .div_cfg_o(div_cfg), .entry_o(entry),
    .irq_o(irq), .irq_vec_o(vec)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every request must match the next expected vector
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9/R8 unexpected request actual=%h expected=none", vec);
      end else begin
        chk("R8 request vector", {24'h0, vec}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [31:0] CFG[5] = '{32'h0, 32'hB, 32'h3, 32'h8, 32'hA};
  localparam int          DIV[5] = '{2, 1, 16, 32, 128};

  initial begin
    idle(3);
    chk("R10 reset count", count, 32'h0);
    chk("R10 reset divide", div_cfg, 32'h0);
    chk("R10 reset entry", entry, 32'h0001_0000);
    chk("R8 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    tick  = 1'b1;

    wr(2'd0, 32'hFFFF_FFFF);
    chk("R1 divide writable bits", div_cfg, 32'hB);
    wr(2'd0, 32'h0000_0004);
    chk("R1 bit2 ignored", div_cfg, 32'h0);

    wr(2'd2, 32'hFFFC_0041);
    chk("R10 entry fields", entry, 32'h0000_0041);

    for (int i = 0; i < 5; i++) begin
      wr(2'd0, CFG[i]);
      wr(2'd1, 32'd5);
      chk("R4 load value", count, 32'd5);
      idle(2 * DIV[i] - 1);
      chk($sformatf("R2 code cfg=%h before step", CFG[i]), count, 32'd4);
      idle(1);
      chk($sformatf("R2 code cfg=%h at step", CFG[i]), count, 32'd3);
      wr(2'd1, 32'd0);
      chk("R5 zero load stops", count, 32'd0);
    end

    // one-shot, divide by 1
    wr(2'd0, 32'hB);
    wr(2'd2, 32'h0000_0041);
    exp_q.push_back(8'h41);
    wr(2'd1, 32'd3);
    idle(3);
    chk("R6 one-shot reaches zero", count, 32'd0);
    idle(5);
    chk("R6 one-shot holds zero", count, 32'd0);
    chk("R6 single request", exp_q.size(), 32'd0);

    // periodic
    wr(2'd2, 32'h0002_0052);
    exp_q.push_back(8'h52);
    exp_q.push_back(8'h52);
    wr(2'd1, 32'd4);
    idle(2);
    chk("R4 periodic decrement", count, 32'd2);
    idle(2);
    chk("R7 periodic reload", count, 32'd4);
    idle(4);
    chk("R7 second reload", count, 32'd4);
    wr(2'd1, 32'd0);
    chk("R7 both requests seen", exp_q.size(), 32'd0);
    idle(10);
    chk("R5 stopped after zero load", count, 32'd0);

    // masked periodic: reload continues, no request
    wr(2'd2, 32'h0003_0052);
    wr(2'd1, 32'd2);
    idle(2);
    chk("R9 masked reload", count, 32'd2);
    idle(1);
    chk("R9 masked continues", count, 32'd1);
    idle(10);
    wr(2'd1, 32'd0);

    // restart on reload, divide by 2
    wr(2'd2, 32'h0000_0041);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd10);
    idle(3);
    chk("R4 count after 3 ticks", count, 32'd9);
    wr(2'd1, 32'd7);
    chk("R4 restart value", count, 32'd7);
    idle(1);
    chk("R4 prescaler restarted", count, 32'd7);
    idle(1);
    chk("R4 first step after restart", count, 32'd6);
    wr(2'd1, 32'd0);

    // tick gating, divide by 1
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd9);
    tick = 1'b0;
    idle(5);
    chk("R3 no tick holds", count, 32'd9);
    tick = 1'b1;
    idle(2);
    chk("R3 ticks resume", count, 32'd7);
    wr(2'd1, 32'd0);

    // software-disabled entry write
    sw_en = 1'b0;
    wr(2'd2, 32'h0000_0041);
    chk("R10 mask forced when disabled", entry, 32'h0001_0041);
    sw_en = 1'b1;
    wr(2'd2, 32'h0000_0041);
    chk("R10 mask free when enabled", entry, 32'h0000_0041);

    idle(4);
    chk("R8 no pending expected requests", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule